// File: doc/BRIEF.md
# Mixed-Width Synchronous FIFO

This block is a single-clock FIFO built on one dual-port bit array with a fixed budget of 4,608 bits. The write port and the read port each take a data width from a small fixed set, and the two widths may differ. A producer can push 4-bit nibbles and a consumer can pull them out as single bits, or a producer can push 9-bit bytes and a consumer can collect them in 18-bit pairs. The block keeps its own write and read address counters, so no address logic is needed around it.

The block keeps the fill level in units of the narrower of the two ports. From that level it produces four status outputs. Two of them are the usual empty and full. The other two are almost-empty and almost-full, and each compares the fill level against a threshold applied on an input port. Either threshold can be changed at run time. When a wide word is split into narrow words, the narrow words come out least-significant part first. When narrow words are combined into a wide word, they are packed in that same order. A write while full is dropped, and so is a read while empty. A read and a write may occur in the same clock cycle.

Top module: `mwfifo_top`

## Requirements
- R1: The widths `WR_W` and `RD_W` must both come from {1,2,4}, which gives a 4,096-bit space, or both from {9,18}, which gives the full 4,608 bits; a mixed pair stops elaboration. With 4-bit writes the FIFO accepts exactly 1,024 writes from empty before it reports full, and with 9-bit writes it accepts exactly 512.
- R2: After the active-low reset, `empty`=1, `full`=0, `almostEmpty`=1, `rdData`=0 and `almostFull` equals (`afLevel`==0).
- R3: When the write port is wider than the read port, each written word is returned over several reads, least-significant bits first.
- R4: When the read port is wider than the write port, the first write of a group lands in the least-significant bits of the word that is read.
- R5: The fill level counts units of the narrower width; `full` is 1 exactly when the free units are fewer than one write word.
- R6: `empty` is 1 exactly when the stored units are fewer than one read word.
- R7: `almostFull` is 1 when the fill level is at or above `afLevel`, and `almostEmpty` is 1 when the fill level is at or below `aeLevel`; both levels are given in narrow units.
- R8: A write while `full` is 1 stores nothing and moves no pointer, so the data read out afterwards is unchanged.
- R9: A read while `empty` is 1 moves no pointer and leaves `rdData` unchanged.
- R10: A read and a write accepted in the same cycle both take effect; the fill level changes by the write step minus the read step.
- R11: `rdData` is a register. It takes the next read word on the clock edge that accepts a read and holds its value on every other edge. All flags reflect the fill level after each edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write request |
| wrData | input | WR_W | Write word |
| rdEn | input | 1 | Read request |
| rdData | output | RD_W | Registered read word |
| aeLevel | input | LW | Almost-empty threshold, in narrow units |
| afLevel | input | LW | Almost-full threshold, in narrow units |
| empty | output | 1 | Fewer stored units than one read word |
| full | output | 1 | Fewer free units than one write word |
| almostEmpty | output | 1 | Fill level at or below `aeLevel` |
| almostFull | output | 1 | Fill level at or above `afLevel` |

## Verification
Two configurations run side by side. One splits 4-bit words into single bits, which tests the sub-word order on the narrowing path. The other joins 9-bit words into 18-bit words, which tests packing on the widening path and the larger bit budget. A long fill pattern drives each FIFO past full, which separates a correct capacity and write blocking from an off-by-one in the full threshold. A full drain with surplus reads does the same for empty and for `rdData` holding its value. Random stimulus, first weighted toward writes and then toward reads, creates many cycles where both ports are accepted at once and moves the fill level back and forth across both programmable thresholds.

// File: rtl/mwfifo_pkg.sv
package mwfifo_pkg;

  localparam int ADDR_BITS = 12;

  typedef struct packed {
    logic                 wrGo;
    logic                 rdGo;
    logic [ADDR_BITS-1:0] wrUnit;
    logic [ADDR_BITS-1:0] rdUnit;
  } mwStrobe_t;

  function automatic bit isNarrowFamily(int w);
    return (w == 1) || (w == 2) || (w == 4);
  endfunction

  function automatic bit isByteFamily(int w);
    return (w == 9) || (w == 18);
  endfunction

  function automatic bit widthsCompatible(int a, int b);
    return (isNarrowFamily(a) && isNarrowFamily(b)) ||
           (isByteFamily(a) && isByteFamily(b));
  endfunction

  function automatic int capBits(int a, int b);
    return (isByteFamily(a) && isByteFamily(b)) ? 4608 : 4096;
  endfunction

  function automatic int minOf(int a, int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int maxOf(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unitCount(int a, int b);
    return capBits(a, b) / minOf(a, b);
  endfunction

  function automatic int lvlBits(int a, int b);
    return $clog2(unitCount(a, b)) + 1;
  endfunction

endpackage

// File: rtl/mwfifo_ctrl.sv
module mwfifo_ctrl
  import mwfifo_pkg::*;
#(
  parameter  int WR_W = 4,
  parameter  int RD_W = 1,
  localparam int LW   = lvlBits(WR_W, RD_W)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [LW-1:0] aeLevel,
  input  logic [LW-1:0] afLevel,
  output mwStrobe_t     strobe,
  output logic          empty,
  output logic          full,
  output logic          almostEmpty,
  output logic          almostFull
);

  localparam int MINW  = minOf(WR_W, RD_W);
  localparam int UNITS = unitCount(WR_W, RD_W);
  localparam int AW    = $clog2(UNITS);
  localparam int WSTEP = WR_W / MINW;
  localparam int RSTEP = RD_W / MINW;

  logic [AW-1:0] wrPtr;
  logic [AW-1:0] rdPtr;
  logic [LW-1:0] fill;
  logic          wrGo;
  logic          rdGo;

  // Flags follow the registered fill level, so they change on the edge
  // that performs the access.
  always_comb begin
    full        = fill > LW'(UNITS - WSTEP);
    empty       = fill < LW'(RSTEP);
    almostFull  = fill >= afLevel;
    almostEmpty = fill <= aeLevel;
    wrGo        = wrEn && !full;
    rdGo        = rdEn && !empty;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (wrGo) wrPtr <= wrPtr + AW'(WSTEP);
      if (rdGo) rdPtr <= rdPtr + AW'(RSTEP);
      fill <= fill + (wrGo ? LW'(WSTEP) : LW'(0)) - (rdGo ? LW'(RSTEP) : LW'(0));
    end
  end

  always_comb begin
    strobe.wrGo   = wrGo;
    strobe.rdGo   = rdGo;
    strobe.wrUnit = ADDR_BITS'(wrPtr);
    strobe.rdUnit = ADDR_BITS'(rdPtr);
  end

  // R5: the fill level never passes the array's unit count
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    fill <= LW'(UNITS));

  // R6: the two end flags are never 1 together
  a_r6_not_full_and_empty: assert property (@(posedge clk) disable iff (!rstN)
    !(full && empty));

  // R8: a blocked write moves no write pointer
  a_r8_full_holds_wrptr: assert property (@(posedge clk) disable iff (!rstN)
    full |=> $stable(wrPtr));

  // R9: a blocked read moves no read pointer
  a_r9_empty_holds_rdptr: assert property (@(posedge clk) disable iff (!rstN)
    empty |=> $stable(rdPtr));

  // R10: an accepted read and write in one cycle change the fill level by the net step
  a_r10_net_step: assert property (@(posedge clk) disable iff (!rstN)
    (wrGo && rdGo) |=> (int'(fill) == int'($past(fill)) + WSTEP - RSTEP));

endmodule

// File: rtl/mwfifo_datapath.sv
module mwfifo_datapath
  import mwfifo_pkg::*;
#(
  parameter int WR_W = 4,
  parameter int RD_W = 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  mwStrobe_t       strobe,
  input  logic [WR_W-1:0] wrData,
  output logic [RD_W-1:0] rdData
);

  localparam int MINW = minOf(WR_W, RD_W);
  localparam int MAXW = maxOf(WR_W, RD_W);
  localparam int SUBS = MAXW / MINW;
  localparam int ROWS = capBits(WR_W, RD_W) / MAXW;
  localparam int RB   = $clog2(ROWS);

  // One row holds one word of the wider port. The narrower port addresses
  // sub-words inside a row, with sub-word 0 in the least-significant bits.
  logic [MAXW-1:0] mem [ROWS];

  logic [RB-1:0] wrRow;
  logic [RB-1:0] rdRow;
  int            wrOff;
  int            rdOff;

  always_comb begin
    wrRow = RB'(int'(strobe.wrUnit) / SUBS);
    rdRow = RB'(int'(strobe.rdUnit) / SUBS);
    wrOff = (int'(strobe.wrUnit) % SUBS) * MINW;
    rdOff = (int'(strobe.rdUnit) % SUBS) * MINW;
  end

  always_ff @(posedge clk) begin
    if (strobe.wrGo) mem[wrRow][wrOff +: WR_W] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (strobe.rdGo) rdData <= mem[rdRow][rdOff +: RD_W];
  end

  // R11: the read register moves only when a read is accepted
  a_r11_hold_without_read: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdGo |=> $stable(rdData));

endmodule

// File: rtl/mwfifo_top.sv
module mwfifo_top
  import mwfifo_pkg::*;
#(
  parameter  int WR_W = 4,
  parameter  int RD_W = 1,
  localparam int LW   = lvlBits(WR_W, RD_W)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [WR_W-1:0] wrData,
  input  logic            rdEn,
  output logic [RD_W-1:0] rdData,
  input  logic [LW-1:0]   aeLevel,
  input  logic [LW-1:0]   afLevel,
  output logic            empty,
  output logic            full,
  output logic            almostEmpty,
  output logic            almostFull
);

  // R1: both widths must come from the same family
  if (!widthsCompatible(WR_W, RD_W)) begin : g_badWidths
    $error("mwfifo_top: write width and read width belong to different families");
  end

  mwStrobe_t strobe;

  mwfifo_ctrl #(.WR_W(WR_W), .RD_W(RD_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .rdEn        (rdEn),
    .aeLevel     (aeLevel),
    .afLevel     (afLevel),
    .strobe      (strobe),
    .empty       (empty),
    .full        (full),
    .almostEmpty (almostEmpty),
    .almostFull  (almostFull)
  );

  mwfifo_datapath #(.WR_W(WR_W), .RD_W(RD_W)) u_data (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (wrData),
    .rdData (rdData)
  );

endmodule

// File: tb/sim_mwfifo_top.sv
`timescale 1ns/1ps
module sim_mwfifo_top;

  localparam int A_WR = 4,  A_RD = 1,  A_CAP = 4096, A_MIN = 1, A_AE = 5, A_AF = 4000;
  localparam int B_WR = 9,  B_RD = 18, B_CAP = 4608, B_MIN = 9, B_AE = 3, B_AF = 500;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic            aWrEn = 0, aRdEn = 0;
  logic [A_WR-1:0] aWrData = '0;
  logic [A_RD-1:0] aRdData;
  logic            aEmpty, aFull, aAe, aAf;

  logic            bWrEn = 0, bRdEn = 0;
  logic [B_WR-1:0] bWrData = '0;
  logic [B_RD-1:0] bRdData;
  logic            bEmpty, bFull, bAe, bAf;

  mwfifo_top #(.WR_W(A_WR), .RD_W(A_RD)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(aWrEn), .wrData(aWrData), .rdEn(aRdEn),
    .rdData(aRdData), .aeLevel(13'(A_AE)), .afLevel(13'(A_AF)),
    .empty(aEmpty), .full(aFull), .almostEmpty(aAe), .almostFull(aAf));

  mwfifo_top #(.WR_W(B_WR), .RD_W(B_RD)) u1 (
    .clk(clk), .rstN(rstN), .wrEn(bWrEn), .wrData(bWrData), .rdEn(bRdEn),
    .rdData(bRdData), .aeLevel(10'(B_AE)), .afLevel(10'(B_AF)),
    .empty(bEmpty), .full(bFull), .almostEmpty(bAe), .almostFull(bAf));

  // Reference model: one bit queue per FIFO, oldest bit at the front.
  bit qa[$];
  bit qb[$];
  logic [A_RD-1:0] expA = '0;
  logic [B_RD-1:0] expB = '0;
  int accA = 0, accB = 0;
  int tests = 0, fails = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic compareAll(input string phase);
    int na, nb;
    na = qa.size() / A_MIN;
    nb = qb.size() / B_MIN;
    // R5 full, R6 empty, R7 thresholds, R3/R4 data order
    check(aFull  == (qa.size() > A_CAP - A_WR), "R5", {phase, " u0 full"},  aFull,  qa.size() > A_CAP - A_WR);
    check(aEmpty == (qa.size() < A_RD),         "R6", {phase, " u0 empty"}, aEmpty, qa.size() < A_RD);
    check(aAe    == (na <= A_AE),               "R7", {phase, " u0 almostEmpty"}, aAe, na <= A_AE);
    check(aAf    == (na >= A_AF),               "R7", {phase, " u0 almostFull"},  aAf, na >= A_AF);
    check(aRdData == expA,                      "R3", {phase, " u0 rdData"}, aRdData, expA);
    check(bFull  == (qb.size() > B_CAP - B_WR), "R5", {phase, " u1 full"},  bFull,  qb.size() > B_CAP - B_WR);
    check(bEmpty == (qb.size() < B_RD),         "R6", {phase, " u1 empty"}, bEmpty, qb.size() < B_RD);
    check(bAe    == (nb <= B_AE),               "R7", {phase, " u1 almostEmpty"}, bAe, nb <= B_AE);
    check(bAf    == (nb >= B_AF),               "R7", {phase, " u1 almostFull"},  bAf, nb >= B_AF);
    check(bRdData == expB,                      "R4", {phase, " u1 rdData"}, bRdData, expB);
  endtask

  // Drive one cycle's requests at the falling edge, update the model, then
  // compare after the next falling edge.
  task automatic cycle(input bit wa, input bit ra, input bit wb, input bit rb,
                       input string phase);
    logic [A_WR-1:0] da;
    logic [B_WR-1:0] db;
    bit fa, ea, fb, eb;
    da = A_WR'($urandom);
    db = B_WR'($urandom);
    fa = qa.size() > A_CAP - A_WR;  ea = qa.size() < A_RD;
    fb = qb.size() > B_CAP - B_WR;  eb = qb.size() < B_RD;
    if (wa && !aFull) accA++;
    if (wb && !bFull) accB++;
    if (ra && !ea) for (int i = 0; i < A_RD; i++) expA[i] = qa.pop_front();
    if (rb && !eb) for (int i = 0; i < B_RD; i++) expB[i] = qb.pop_front();
    if (wa && !fa) for (int i = 0; i < A_WR; i++) qa.push_back(da[i]);
    if (wb && !fb) for (int i = 0; i < B_WR; i++) qb.push_back(db[i]);
    aWrEn = wa; aRdEn = ra; aWrData = da;
    bWrEn = wb; bRdEn = rb; bWrData = db;
    @(negedge clk);
    compareAll(phase);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    compareAll("R2 reset");
    check(aAe == 1'b1 && bAe == 1'b1, "R2", "almostEmpty after reset", {aAe, bAe}, 2'b11);

    // Fill past full: writes beyond capacity must be dropped (R8).
    for (int i = 0; i < 1100; i++) cycle(1, 0, 1, 0, "R8 fill");
    check(accA == A_CAP / A_WR, "R1", "u0 accepted writes", accA, A_CAP / A_WR);
    check(accB == B_CAP / B_WR, "R1", "u1 accepted writes", accB, B_CAP / B_WR);

    // Drain past empty: surplus reads leave rdData held (R9, R11).
    for (int i = 0; i < 4200; i++) cycle(0, 1, 0, 1, "R9 drain");
    for (int i = 0; i < 8; i++) cycle(0, 0, 0, 0, "R11 idle");

    // Write-heavy then read-heavy random mixes with simultaneous access (R10).
    for (int i = 0; i < 2500; i++)
      cycle(($urandom % 10) < 7, ($urandom % 10) < 4,
            ($urandom % 10) < 7, ($urandom % 10) < 4, "R10 mix-up");
    for (int i = 0; i < 2500; i++)
      cycle(($urandom % 10) < 4, ($urandom % 10) < 7,
            ($urandom % 10) < 4, ($urandom % 10) < 7, "R10 mix-down");
    for (int i = 0; i < 300; i++) cycle(1, 1, 1, 1, "R10 both");

    finishRun();
  end

endmodule